// File: doc/BRIEF.md
# Saturating Y-Extended Integer Divider

This block divides a 64-bit dividend by a 32-bit divisor and returns a result that always fits a 32-bit quotient range. The upper half of the dividend comes from a separate Y operand and the lower half from the first source operand. The divisor is the second operand. In unsigned mode a quotient too wide for 32 bits is clamped to the largest unsigned 32-bit value. In signed mode it is clamped to the largest positive value or the most negative value, and an overflow flag reports the clamp. A zero divisor raises a fault and produces no quotient.

The divider is sequential and restoring. It works on magnitudes, producing one quotient bit per clock over 64 clocks. Signed results get their sign applied afterwards. Operands enter through a valid/ready pair. `in_ready` is high whenever no division is in flight, and a request is taken on any rising edge where `in_valid` and `in_ready` are both high. While a division runs, `in_ready` stays low and `in_valid` has no effect. The result side has no back-pressure: `out_valid` is high for exactly one cycle and the consumer must capture the result in that cycle.

Top module: `ydiv_sat`

## Requirements
- R1: The dividend is `{in_y, in_rs1}`, with `in_y` in bits 63:32 and `in_rs1` in bits 31:0. The quotient truncates toward zero.
- R2: If the divisor is zero, the cycle right after the accepting edge shows `out_valid`=1, `out_divzero`=1, `out_result`=0 and `out_overflow`=0, and no division is started.
- R3: In unsigned mode (`in_signed`=0), a quotient above 0xFFFFFFFF gives `out_result`=0x00000000FFFFFFFF with `out_overflow`=1. Any other quotient is returned zero-extended with `out_overflow`=0.
- R4: In signed mode (`in_signed`=1), a non-negative quotient above 0x7FFFFFFF gives `out_result`=0x000000007FFFFFFF with `out_overflow`=1.
- R5: In signed mode, the quotient sign is the XOR of the operand signs. A negative quotient below -2^31 gives `out_result`=0xFFFFFFFF80000000 with `out_overflow`=1. An in-range negative quotient is sign-extended to 64 bits with `out_overflow`=0.
- R6: `out_carry` is 0 on every completed operation.
- R7: For a nonzero divisor, `out_valid` rises in the cycle after the 64th rising edge following the accepting edge, and it stays high for one cycle only.
- R8: `in_ready` is low from the accepting edge of a nonzero-divisor request until the result cycle. `in_valid` asserted while `in_ready` is low changes neither the pending result nor the number of results produced.
- R9: During and right after reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request carries valid operands |
| in_ready | output | 1 | Divider can take a request this cycle |
| in_signed | input | 1 | 1 = signed mode, 0 = unsigned mode |
| in_y | input | 32 | Upper half of the dividend |
| in_rs1 | input | 32 | Lower half of the dividend |
| in_divisor | input | 32 | Divisor |
| out_valid | output | 1 | Result present, one cycle |
| out_result | output | 64 | Saturated quotient, 64-bit destination value |
| out_overflow | output | 1 | Overflow flag (V): quotient was clamped |
| out_carry | output | 1 | Carry flag (C), always cleared |
| out_divzero | output | 1 | Divide-by-zero fault |

## Verification
The hardest cases to reach from the ports are signed quotients sitting exactly on the clamp limits: +2^31-1, +2^31, -2^31 and -2^31-1. The most extreme dividend, -2^63 divided by -1, is also hard to hit. Random operands almost never land on these values. The bench therefore builds directed dividends from a chosen quotient and divisor, with the Y half set to the sign extension or one past it. Random traffic then adds a mix of Y values: zero, small, sign-extended and fully random. This spreads the cases over in-range and clamped results in both modes.

// File: rtl/ydiv_pkg.sv
`timescale 1ns/1ps
package ydiv_pkg;
  // Operating mode of one division request
  typedef enum logic {
    DIV_UNSIGNED = 1'b0,
    DIV_SIGNED   = 1'b1
  } div_mode_e;
endpackage

// File: rtl/ydiv_prep.sv
`timescale 1ns/1ps
// Converts raw operands into magnitudes and the quotient sign.
module ydiv_prep #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W
) (
  input  ydiv_pkg::div_mode_e mode,
  input  logic [HALF_W-1:0]   hi,
  input  logic [HALF_W-1:0]   lo,
  input  logic [HALF_W-1:0]   dsr,
  output logic [FULL_W-1:0]   dvd_mag,
  output logic [HALF_W-1:0]   dsr_mag,
  output logic                q_neg,
  output logic                dsr_zero
);
  logic              dvd_neg;
  logic              dsr_neg;
  logic [FULL_W-1:0] dvd_raw;

  always_comb begin
    dvd_raw  = {hi, lo};
    dvd_neg  = (mode == ydiv_pkg::DIV_SIGNED) && hi[HALF_W-1];
    dsr_neg  = (mode == ydiv_pkg::DIV_SIGNED) && dsr[HALF_W-1];
    dvd_mag  = dvd_neg ? (~dvd_raw + 1'b1) : dvd_raw;
    dsr_mag  = dsr_neg ? (~dsr + 1'b1) : dsr;
    q_neg    = dvd_neg ^ dsr_neg;
    dsr_zero = (dsr == '0);
  end
endmodule

// File: rtl/ydiv_core.sv
`timescale 1ns/1ps
// Restoring magnitude divider: one quotient bit per clock.
module ydiv_core #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W,
  localparam int CNT_W  = $clog2(FULL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FULL_W-1:0] dvd,
  input  logic [HALF_W-1:0] dsr,
  output logic              busy,
  output logic              done,
  output logic [FULL_W-1:0] quo
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FULL_W - 1);

  logic              busy_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HALF_W-1:0] rem_q, dsr_q;
  logic [FULL_W-1:0] quo_q;

  logic [HALF_W:0]   shifted, trial;
  logic              take;
  logic [HALF_W-1:0] rem_nxt;
  logic [FULL_W-1:0] quo_nxt;

  // The quotient register shifts dividend bits out at the top and
  // collects quotient bits at the bottom.
  always_comb begin
    shifted = {rem_q, quo_q[FULL_W-1]};
    trial   = shifted - {1'b0, dsr_q};
    take    = ~trial[HALF_W];
    rem_nxt = take ? trial[HALF_W-1:0] : shifted[HALF_W-1:0];
    quo_nxt = {quo_q[FULL_W-2:0], take};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        rem_q <= rem_nxt;
        quo_q <= quo_nxt;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= '0;
        dsr_q  <= dsr;
        quo_q  <= dvd;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/ydiv_sat_stage.sv
`timescale 1ns/1ps
// Applies sign and clamps the magnitude quotient to the 32-bit range.
module ydiv_sat_stage #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W
) (
  input  ydiv_pkg::div_mode_e mode,
  input  logic                q_neg,
  input  logic [FULL_W-1:0]   quo_mag,
  output logic [FULL_W-1:0]   result,
  output logic                ovf
);
  localparam logic [FULL_W-1:0] U_MAX     = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [FULL_W-1:0] S_POS_MAX = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [FULL_W-1:0] S_NEG_MAG = {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [FULL_W-1:0] S_NEG_MIN = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

  always_comb begin
    if (mode == ydiv_pkg::DIV_UNSIGNED) begin
      ovf    = |quo_mag[FULL_W-1:HALF_W];
      result = ovf ? U_MAX : quo_mag;
    end else if (!q_neg) begin
      ovf    = quo_mag > S_POS_MAX;
      result = ovf ? S_POS_MAX : quo_mag;
    end else begin
      ovf    = quo_mag > S_NEG_MAG;
      result = ovf ? S_NEG_MIN : (~quo_mag + 1'b1);
    end
  end
endmodule

// File: rtl/ydiv_sat.sv
`timescale 1ns/1ps
// Top level: 64-by-32 divider with Y-extended dividend and saturation.
module ydiv_sat #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_signed,
  input  logic [HALF_W-1:0] in_y,
  input  logic [HALF_W-1:0] in_rs1,
  input  logic [HALF_W-1:0] in_divisor,
  output logic              out_valid,
  output logic [FULL_W-1:0] out_result,
  output logic              out_overflow,
  output logic              out_carry,
  output logic              out_divzero
);
  ydiv_pkg::div_mode_e in_mode, mode_q;
  logic              neg_q, dz_q;
  logic              accept, core_start, core_busy, core_done;
  logic [FULL_W-1:0] dvd_mag, quo_mag, sat_res;
  logic [HALF_W-1:0] dsr_mag;
  logic              q_neg, dsr_zero, sat_ovf;

  assign in_mode    = in_signed ? ydiv_pkg::DIV_SIGNED : ydiv_pkg::DIV_UNSIGNED;
  assign in_ready   = ~core_busy;
  assign accept     = in_valid & in_ready;
  assign core_start = accept & ~dsr_zero;

  ydiv_prep #(.HALF_W(HALF_W)) u_prep (
    .mode     (in_mode),
    .hi       (in_y),
    .lo       (in_rs1),
    .dsr      (in_divisor),
    .dvd_mag  (dvd_mag),
    .dsr_mag  (dsr_mag),
    .q_neg    (q_neg),
    .dsr_zero (dsr_zero)
  );

  ydiv_core #(.HALF_W(HALF_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .start (core_start),
    .dvd   (dvd_mag),
    .dsr   (dsr_mag),
    .busy  (core_busy),
    .done  (core_done),
    .quo   (quo_mag)
  );

  ydiv_sat_stage #(.HALF_W(HALF_W)) u_sat (
    .mode    (mode_q),
    .q_neg   (neg_q),
    .quo_mag (quo_mag),
    .result  (sat_res),
    .ovf     (sat_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ydiv_pkg::DIV_UNSIGNED;
      neg_q  <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      dz_q <= accept & dsr_zero;
      if (accept) begin
        mode_q <= in_mode;
        neg_q  <= q_neg;
      end
    end
  end

  assign out_valid    = core_done | dz_q;
  assign out_divzero  = dz_q;
  assign out_result   = core_done ? sat_res : '0;
  assign out_overflow = core_done & sat_ovf;
  assign out_carry    = 1'b0;
endmodule

// File: rtl/ydiv_sat_chk.sv
`timescale 1ns/1ps
// Property checker bound into ydiv_sat.
module ydiv_sat_chk #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W,
  localparam int LAT    = FULL_W,
  localparam int CW     = $clog2(LAT) + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [HALF_W-1:0] in_divisor,
  input logic              out_valid,
  input logic [FULL_W-1:0] out_result,
  input logic              out_overflow,
  input logic              out_divzero,
  input logic              mode_q,
  input logic              neg_q
);
  localparam logic [FULL_W-1:0] U_MAX     = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [FULL_W-1:0] S_POS_MAX = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [FULL_W-1:0] S_NEG_MIN = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          acc;
  assign acc = in_valid && in_ready;

  // Cycle counter since the last accepted nonzero-divisor request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (acc && in_divisor != '0) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (out_valid) run_q <= 1'b0;
      else           cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r2_divzero_next: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_divisor == '0) |=> (out_valid && out_divzero));

  a_r2_divzero_empty: assert property (@(posedge clk) disable iff (!rst_n)
    out_divzero |-> (out_result == '0 && !out_overflow));

  a_r3_unsigned_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow && !mode_q) |-> out_result == U_MAX);

  a_r3_unsigned_width: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mode_q) |-> out_result[FULL_W-1:HALF_W] == '0);

  a_r4_signed_pos_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow && mode_q && !neg_q) |-> out_result == S_POS_MAX);

  a_r5_signed_neg_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow && mode_q && neg_q) |-> out_result == S_NEG_MIN);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_divzero) |-> (run_q && cnt_q == CW'(LAT)));

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_divisor != '0) |=> !in_ready);

  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(mode_q) && $stable(neg_q)));
endmodule

bind ydiv_sat ydiv_sat_chk #(.HALF_W(HALF_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_divisor   (in_divisor),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_overflow (out_overflow),
  .out_divzero  (out_divzero),
  .mode_q       (mode_q),
  .neg_q        (neg_q)
);

// File: tb/ydiv_sat_bench.sv
`timescale 1ns/1ps
module ydiv_sat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_signed = 1'b0;
  logic [31:0] in_y = '0, in_rs1 = '0, in_divisor = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_overflow, out_carry, out_divzero;

  int checks = 0;
  int errs   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ydiv_sat u_ydiv_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_signed(in_signed), .in_y(in_y), .in_rs1(in_rs1), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_result(out_result), .out_overflow(out_overflow),
    .out_carry(out_carry), .out_divzero(out_divzero)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errs++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Expected behaviour computed from the requirements.
  function automatic void ref_div(input bit sg, input logic [31:0] y, input logic [31:0] lo,
                                  input logic [31:0] d, output logic [63:0] res,
                                  output bit ovf, output string tag);
    logic [63:0] dvd, am, bm, qm;
    bit an, bn, neg;
    dvd = {y, lo};
    an  = sg && y[31];
    bn  = sg && d[31];
    am  = an ? -dvd : dvd;
    bm  = bn ? -{32'h0, d} & 64'hFFFF_FFFF : {32'h0, d};
    neg = an ^ bn;
    if (d == 0) begin
      res = '0; ovf = 0; tag = "R2";
      return;
    end
    qm = am / bm;
    if (!sg) begin
      ovf = qm > 64'hFFFF_FFFF;
      res = ovf ? 64'hFFFF_FFFF : qm;
      tag = "R3";
    end else if (!neg) begin
      ovf = qm > 64'h7FFF_FFFF;
      res = ovf ? 64'h7FFF_FFFF : qm;
      tag = ovf ? "R4" : "R1";
    end else begin
      ovf = qm > 64'h8000_0000;
      res = ovf ? 64'hFFFF_FFFF_8000_0000 : -qm;
      tag = "R5";
    end
  endfunction

  task automatic run_op(input bit sg, input logic [31:0] y, input logic [31:0] lo,
                        input logic [31:0] d);
    logic [63:0] er; bit eo; string tag; int k;
    ref_div(sg, y, lo, d, er, eo, tag);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_signed = sg; in_y = y; in_rs1 = lo; in_divisor = d;
    @(negedge clk);
    in_valid = 1'b0;
    k = 0;
    while (!out_valid && k < 200) begin
      @(negedge clk);
      k++;
    end
    check({tag, " R7 latency"}, 64'(k), (d == 0) ? 64'd0 : 64'd64);
    check({tag, " R2 divzero flag"}, {63'h0, out_divzero}, {63'h0, d == 0});
    check({tag, " result"}, out_result, er);
    check({tag, " overflow"}, {63'h0, out_overflow}, {63'h0, eo});
    check("R6 carry", {63'h0, out_carry}, 64'h0);
    @(negedge clk);
    check("R7 single-cycle out_valid", {63'h0, out_valid}, 64'h0);
  endtask

  initial begin
    logic [63:0] er; bit eo; string tag; int seen;
    void'($urandom(32'h5EED_1234));
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", {63'h0, out_valid}, 64'h0);
    check("R9 in_ready in reset", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", {63'h0, out_valid}, 64'h0);
    check("R9 in_ready after reset", {63'h0, in_ready}, 64'h1);

    // R1 dividend formation
    run_op(0, 32'h1, 32'h0, 32'h2);
    run_op(0, 32'h3, 32'h1, 32'h4);
    // R3 unsigned boundary and clamp
    run_op(0, 32'h0, 32'hFFFF_FFFF, 32'h1);
    run_op(0, 32'h1, 32'h0, 32'h1);
    run_op(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R2 zero divisor, both modes, back to back
    run_op(0, 32'h1234, 32'h5678, 32'h0);
    run_op(1, 32'hFFFF_FFFF, 32'h5678, 32'h0);
    // R4 positive limits
    run_op(1, 32'h0, 32'h7FFF_FFFF, 32'h1);
    run_op(1, 32'h0, 32'h8000_0000, 32'h1);
    run_op(1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF);
    // R5 negative limits, truncation, negative zero
    run_op(1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1);
    run_op(1, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op(1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1);
    run_op(1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'h2);
    run_op(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h2);
    run_op(1, 32'h0000_0001, 32'h0, 32'hFFFF_FFFE);

    // R8: requests while busy are ignored
    ref_div(0, 32'h0, 32'd1000, 32'd7, er, eo, tag);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_signed = 0; in_y = 0; in_rs1 = 32'd1000; in_divisor = 32'd7;
    @(negedge clk);
    in_signed = 1; in_y = 32'hFFFF_FFFF; in_rs1 = 32'h1; in_divisor = 32'h3;
    for (int i = 0; i < 3; i++) begin
      check("R8 in_ready low while busy", {63'h0, in_ready}, 64'h0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    check("R8 pending result kept", out_result, er);
    seen = 0;
    @(negedge clk);
    for (int i = 0; i < 70; i++) begin
      if (out_valid) seen++;
      @(negedge clk);
    end
    check("R8 no extra result", 64'(seen), 64'h0);

    // Random traffic
    for (int n = 0; n < 250; n++) begin
      bit sg; logic [31:0] y, lo, d; int sel;
      sg  = $urandom_range(0, 1);
      lo  = $urandom;
      sel = $urandom_range(0, 3);
      case (sel)
        0: y = 32'h0;
        1: y = $urandom_range(0, 255);
        2: y = {32{lo[31]}};
        default: y = $urandom;
      endcase
      d = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 15)) : $urandom;
      run_op(sg, y, lo, d);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule